// File: doc/BRIEF.md
# USB packet field parser

This block sits behind a USB line decoder that has already removed NRZI coding and stuffed bits. It takes the recovered bit stream one bit per `bit_vld` cycle, least significant bit first. A `sop` strobe opens each packet and an `eop` strobe closes it. From the first sixteen bits the block checks the synchronisation byte and classifies the packet identifier. It then takes apart the class-specific body:

- device address and endpoint for OUT, IN and SETUP tokens;
- the frame number for start-of-frame packets;
- a byte stream for DATA0 and DATA1 packets.

The trailing check bits are never treated as field or payload data. The block does not compute any CRC.

Payload bits pass through a 24-bit window. A byte is released only once sixteen more bits have arrived behind it. One released byte is held back until the next release or the end of the packet, so the last byte can carry a last flag. Token and frame fields are reported on the cycle after end-of-packet, and only when the packet length is exactly 32 bits. Any other length raises a length error.

Top module: `usb_pkt_parser`

## Requirements
- R1: One cycle after the 8th bit of a packet, `err_sync` pulses for one cycle if those eight bits, in arrival order, are not 0,0,0,0,0,0,0,1. The arrival-first bit is bit 0, so the value 8'h80 is the good pattern.
- R2: One cycle after the 16th bit, `pid_vld` pulses for one cycle. At that point `pid_raw` holds bits 8..15, with the first arriving bit at bit 0. `pid_kind` reads OUT=1 (8'hE1), IN=2 (8'h69), SOF=3 (8'hA5), SETUP=4 (8'h2D), DATA0=5 (8'hC3), DATA1=6 (8'h4B), ACK=7 (8'hD2), NAK=8 (8'h5A), STALL=9 (8'h1E), NYET=10 (8'h96).
- R3: A `pid_raw` value outside the R2 list gives `pid_kind`=0, and the raw value is still exposed on `pid_raw`.
- R4: For a 32-bit OUT, IN or SETUP packet, `tok_vld` pulses one cycle after `eop`. `tok_addr` then holds bits 16..22 and `tok_ep` holds bits 23..26, each with its lowest bit arriving first.
- R5: For a 32-bit SOF packet, `frame_vld` pulses one cycle after `eop`, with `frame_num` equal to bits 16..26, lowest bit arriving first. `tok_vld` stays low.
- R6: A token or SOF packet whose bit count at `eop` is not 32 pulses `err_len` one cycle after `eop`, and neither `tok_vld` nor `frame_vld` pulses. This also holds for a 16-bit packet.
- R7: For DATA0/DATA1, bits from 16 onward are grouped into bytes, lowest bit arriving first. A byte is emitted only if at least 16 further bits follow it, so the final 16 bits are never emitted.
- R8: Exactly one emitted byte carries `byte_last`, the final one, and it appears one cycle after `eop`. A packet with no payload emits no byte.
- R9: Cycles with `bit_vld` low between bits do not change any result.
- R10: After reset, all strobes and error flags are low and `pid_kind` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sop | input | 1 | Start-of-packet strobe, ahead of the first bit |
| eop | input | 1 | End-of-packet strobe, after the last bit |
| bit_vld | input | 1 | A bit is present on `bit_in` |
| bit_in | input | 1 | Decoded packet bit |
| pid_vld | output | 1 | Identifier decoded |
| pid_kind | output | 4 | Packet identifier kind code |
| pid_raw | output | 8 | Raw identifier byte |
| err_sync | output | 1 | Bad synchronisation byte |
| tok_vld | output | 1 | Token fields valid |
| tok_addr | output | 7 | Device address |
| tok_ep | output | 4 | Endpoint number |
| frame_vld | output | 1 | Frame number valid |
| frame_num | output | 11 | Frame number |
| err_len | output | 1 | Token or SOF length wrong |
| byte_vld | output | 1 | Payload byte valid |
| byte_data | output | 8 | Payload byte |
| byte_last | output | 1 | Final payload byte |

## Verification
`err_sync` is due one cycle after the 8th bit, and `pid_vld` one cycle after the 16th bit. The token, frame, length-error and last-byte outputs are due one cycle after `eop`. Bytes that are not last come out one cycle after the bit that completes the next held byte. The bench drives on falling edges and reads each of these outputs at the very next falling edge after the edge that consumes the bit or strobe, so a result that is a cycle late or early is reported. Payload bytes are gathered by a falling-edge monitor and compared after the packet has finished.

// File: rtl/upk_pkg.sv
// Shared types for the USB packet field parser.
// Assumes bit 0 of every multi-bit value is the first bit to arrive.
package upk_pkg;
    typedef enum logic [3:0] {
        PK_UNKNOWN = 4'd0,
        PK_OUT     = 4'd1,
        PK_IN      = 4'd2,
        PK_SOF     = 4'd3,
        PK_SETUP   = 4'd4,
        PK_DATA0   = 4'd5,
        PK_DATA1   = 4'd6,
        PK_ACK     = 4'd7,
        PK_NAK     = 4'd8,
        PK_STALL   = 4'd9,
        PK_NYET    = 4'd10
    } pid_kind_e;

    localparam int          SYNC_BITS = 8;
    localparam int          HDR_BITS  = 16;
    localparam logic [7:0]  SYNC_VAL  = 8'h80;
endpackage

// File: rtl/upk_pid_decode.sv
// Identifier classifier: maps a raw identifier byte (first arriving bit at
// bit 0) to a kind code. Purely combinational; unlisted codes give PK_UNKNOWN.
module upk_pid_decode
    import upk_pkg::*;
(
    input  logic [7:0] code,
    output pid_kind_e  kind
);
    // Table lookup of the ten defined identifiers.
    always_comb begin
        unique case (code)
            8'hE1:   kind = PK_OUT;
            8'h69:   kind = PK_IN;
            8'hA5:   kind = PK_SOF;
            8'h2D:   kind = PK_SETUP;
            8'hC3:   kind = PK_DATA0;
            8'h4B:   kind = PK_DATA1;
            8'hD2:   kind = PK_ACK;
            8'h5A:   kind = PK_NAK;
            8'h1E:   kind = PK_STALL;
            8'h96:   kind = PK_NYET;
            default: kind = PK_UNKNOWN;
        endcase
    end
endmodule

// File: rtl/upk_token_fields.sv
// Token and frame field extractor. It collects the FLD_W bits that follow the
// header and, at end-of-packet, reports them when the length equals TOK_BITS,
// or flags a length error otherwise. Assumes eop never coincides with bit_vld.
module upk_token_fields
    import upk_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 7,
    parameter int EP_W   = 4,
    parameter int CRC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sop,
    input  logic              eop,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic [CNT_W-1:0]  cnt,
    input  pid_kind_e         kind,
    output logic              tok_vld,
    output logic [ADDR_W-1:0] tok_addr,
    output logic [EP_W-1:0]   tok_ep,
    output logic              frame_vld,
    output logic [ADDR_W+EP_W-1:0] frame_num,
    output logic              err_len
);
    localparam int FLD_W    = ADDR_W + EP_W;
    localparam int TOK_BITS = HDR_BITS + FLD_W + CRC_W;

    logic [FLD_W-1:0] fld;
    logic             in_fld, is_tok, is_sof, len_ok;

    assign in_fld = bit_vld && (cnt >= CNT_W'(HDR_BITS)) && (cnt < CNT_W'(HDR_BITS + FLD_W));
    assign is_tok = (kind == PK_OUT) || (kind == PK_IN) || (kind == PK_SETUP);
    assign is_sof = (kind == PK_SOF);
    assign len_ok = (cnt == CNT_W'(TOK_BITS));

    // Shift field bits in at the top so the first arriving bit ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || sop) fld <= '0;
        else if (in_fld)   fld <= {bit_in, fld[FLD_W-1:1]};
    end

    // Issue field strobes or the length error on the cycle after eop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tok_vld   <= 1'b0;
            frame_vld <= 1'b0;
            err_len   <= 1'b0;
        end else begin
            tok_vld   <= eop && is_tok && len_ok;
            frame_vld <= eop && is_sof && len_ok;
            err_len   <= eop && (is_tok || is_sof) && !len_ok;
        end
    end

    assign tok_addr  = fld[ADDR_W-1:0];
    assign tok_ep    = fld[FLD_W-1:ADDR_W];
    assign frame_num = fld;

    // R6
    len_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_len |-> (!tok_vld && !frame_vld));
    // R5
    tok_frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tok_vld && frame_vld));
endmodule

// File: rtl/upk_payload_buf.sv
// Payload byte assembler for data packets. Bits after the header pass through
// a HOLD+8 bit window; a byte leaves only when HOLD bits follow it. One byte
// is held pending so the final one can be flagged at end-of-packet.
// Assumes a header length that is a whole number of bytes.
module upk_payload_buf
    import upk_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int HOLD   = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sop,
    input  logic              eop,
    input  logic              bit_vld,
    input  logic              bit_in,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              is_data,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_last
);
    localparam int WIN = HOLD + BYTE_W;

    logic [WIN-1:0]    win, win_next;
    logic [BYTE_W-1:0] pend;
    logic              pend_v, in_pay, rel;
    logic [CNT_W-1:0]  pay_idx;

    assign win_next = {bit_in, win[WIN-1:1]};
    assign in_pay   = bit_vld && is_data && (cnt >= CNT_W'(HDR_BITS));
    assign pay_idx  = cnt - CNT_W'(HDR_BITS);
    assign rel      = in_pay && (pay_idx >= CNT_W'(WIN - 1))
                      && ((pay_idx % CNT_W'(BYTE_W)) == CNT_W'(BYTE_W - 1));

    // Shift payload bits through the hold window.
    always_ff @(posedge clk) begin
        if (!rst_n || sop) win <= '0;
        else if (in_pay)   win <= win_next;
    end

    // Release the pending byte on each new release or, flagged last, at eop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= '0;
            pend_v    <= 1'b0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
            byte_last <= 1'b0;
        end else begin
            byte_vld  <= 1'b0;
            byte_last <= 1'b0;
            if (sop) begin
                pend_v <= 1'b0;
            end else if (rel) begin
                byte_data <= pend;
                byte_vld  <= pend_v;
                pend      <= win_next[BYTE_W-1:0];
                pend_v    <= 1'b1;
            end else if (eop && pend_v) begin
                byte_data <= pend;
                byte_vld  <= 1'b1;
                byte_last <= 1'b1;
                pend_v    <= 1'b0;
            end
        end
    end

    // R8
    last_has_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |-> byte_vld);
    // R8
    last_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_last |-> $past(eop));
endmodule

// File: rtl/usb_pkt_parser.sv
// USB packet field parser top. It counts bits from sop, checks the sync byte,
// captures and classifies the identifier, and hands the body to the token
// and payload units. Assumes sop, eop and bit_vld are never high together.
module usb_pkt_parser
    import upk_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 7,
    parameter int EP_W   = 4,
    parameter int TCRC_W = 5,
    parameter int DCRC_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sop,
    input  logic                   eop,
    input  logic                   bit_vld,
    input  logic                   bit_in,
    output logic                   pid_vld,
    output logic [3:0]             pid_kind,
    output logic [7:0]             pid_raw,
    output logic                   err_sync,
    output logic                   tok_vld,
    output logic [ADDR_W-1:0]      tok_addr,
    output logic [EP_W-1:0]        tok_ep,
    output logic                   frame_vld,
    output logic [ADDR_W+EP_W-1:0] frame_num,
    output logic                   err_len,
    output logic                   byte_vld,
    output logic [7:0]             byte_data,
    output logic                   byte_last
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_BITS - 1);
    localparam logic [CNT_W-1:0] PID_END  = CNT_W'(HDR_BITS - 1);

    logic [CNT_W-1:0] cnt;
    logic [7:0]       hdr_sh, hdr_next;
    pid_kind_e        kind_q, kind_d;
    logic             in_hdr, is_data;

    assign hdr_next = {bit_in, hdr_sh[7:1]};
    assign in_hdr   = bit_vld && (cnt < CNT_W'(HDR_BITS));
    assign is_data  = (kind_q == PK_DATA0) || (kind_q == PK_DATA1);

    // Bit counter: index of the next bit, restarted by sop, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || sop)                  cnt <= '0;
        else if (bit_vld && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Header shifter for the sync and identifier bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || sop) hdr_sh <= '0;
        else if (in_hdr)   hdr_sh <= hdr_next;
    end

    upk_pid_decode u_dec (.code(hdr_next), .kind(kind_d));

    // Sync check and identifier capture at the header byte boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_sync <= 1'b0;
            pid_vld  <= 1'b0;
            pid_raw  <= '0;
            kind_q   <= PK_UNKNOWN;
        end else begin
            err_sync <= bit_vld && (cnt == SYNC_END) && (hdr_next != SYNC_VAL);
            pid_vld  <= bit_vld && (cnt == PID_END);
            if (sop) begin
                kind_q <= PK_UNKNOWN;
            end else if (bit_vld && cnt == PID_END) begin
                pid_raw <= hdr_next;
                kind_q  <= kind_d;
            end
        end
    end

    assign pid_kind = kind_q;

    upk_token_fields #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .EP_W(EP_W), .CRC_W(TCRC_W)
    ) u_tok (
        .clk(clk), .rst_n(rst_n), .sop(sop), .eop(eop),
        .bit_vld(bit_vld), .bit_in(bit_in), .cnt(cnt), .kind(kind_q),
        .tok_vld(tok_vld), .tok_addr(tok_addr), .tok_ep(tok_ep),
        .frame_vld(frame_vld), .frame_num(frame_num), .err_len(err_len)
    );

    upk_payload_buf #(
        .CNT_W(CNT_W), .HOLD(DCRC_W), .BYTE_W(8)
    ) u_pay (
        .clk(clk), .rst_n(rst_n), .sop(sop), .eop(eop),
        .bit_vld(bit_vld), .bit_in(bit_in), .cnt(cnt), .is_data(is_data),
        .byte_vld(byte_vld), .byte_data(byte_data), .byte_last(byte_last)
    );

    // R2
    pid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pid_vld |=> !pid_vld);
    // R1
    sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_sync |=> !err_sync);
    // R7
    bytes_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !byte_last) |-> $past(is_data && bit_vld));
endmodule

// File: tb/tb_usb_pkt_parser.sv
module tb_usb_pkt_parser;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst_n = 1'b0, sop = 1'b0, eop = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
    logic pid_vld, err_sync, tok_vld, frame_vld, err_len, byte_vld, byte_last;
    logic [3:0] pid_kind;
    logic [7:0] pid_raw, byte_data;
    logic [6:0] tok_addr;
    logic [3:0] tok_ep;
    logic [10:0] frame_num;

    usb_pkt_parser dut (
        .clk(clk), .rst_n(rst_n), .sop(sop), .eop(eop), .bit_vld(bit_vld), .bit_in(bit_in),
        .pid_vld(pid_vld), .pid_kind(pid_kind), .pid_raw(pid_raw), .err_sync(err_sync),
        .tok_vld(tok_vld), .tok_addr(tok_addr), .tok_ep(tok_ep), .frame_vld(frame_vld),
        .frame_num(frame_num), .err_len(err_len), .byte_vld(byte_vld),
        .byte_data(byte_data), .byte_last(byte_last)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0, checks = 0;
    logic [511:0] pk;
    int n;
    logic o_sync, o_pidv, o_tok, o_frm, o_len, o_last;
    logic [3:0] o_kind;
    logic [7:0] o_raw;
    logic [6:0] o_addr;
    logic [3:0] o_ep;
    logic [10:0] o_fnum;
    logic [7:0] rx [0:15];
    logic rx_last [0:15];
    int nrx = 0;

    // Payload monitor: collects emitted bytes, cleared by sop.
    always @(negedge clk) begin
        if (sop) nrx = 0;
        else if (byte_vld && nrx < 16) begin
            rx[nrx] = byte_data;
            rx_last[nrx] = byte_last;
            nrx = nrx + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic put(input logic [31:0] v, input int w);
        for (int i = 0; i < w; i++) begin
            pk[n] = v[i];
            n++;
        end
    endtask

    function automatic logic [3:0] exp_kind(input logic [7:0] v);
        case (v)
            8'hE1: return 4'd1;  8'h69: return 4'd2;  8'hA5: return 4'd3;
            8'h2D: return 4'd4;  8'hC3: return 4'd5;  8'h4B: return 4'd6;
            8'hD2: return 4'd7;  8'h5A: return 4'd8;  8'h1E: return 4'd9;
            8'h96: return 4'd10; default: return 4'd0;
        endcase
    endfunction

    // Drive pk[0..n-1]; sample each result at the negedge after its edge.
    task automatic send(input bit gaps);
        @(negedge clk); sop = 1'b1;
        @(negedge clk); sop = 1'b0;
        o_pidv = 1'b0; o_sync = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit_vld = 1'b1; bit_in = pk[i];
            @(negedge clk);
            bit_vld = 1'b0;
            if (i == 7) o_sync = err_sync;
            if (i == 15) begin o_pidv = pid_vld; o_kind = pid_kind; o_raw = pid_raw; end
            if (gaps && (i % 3 == 1)) @(negedge clk);
        end
        eop = 1'b1;
        @(negedge clk); eop = 1'b0;
        o_tok = tok_vld; o_frm = frame_vld; o_len = err_len; o_last = byte_last;
        o_addr = tok_addr; o_ep = tok_ep; o_fnum = frame_num;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!pid_vld && !err_sync && !tok_vld && !frame_vld && !err_len && !byte_vld && !byte_last,
            "R10 strobes after reset", {pid_vld, err_sync, tok_vld, frame_vld, err_len, byte_vld, byte_last}, 0);
        chk(pid_kind == 4'd0, "R10 pid_kind after reset", pid_kind, 0);
        rst_n = 1'b1;

        // R2 R3 R6: every identifier value in a 16-bit packet
        for (int v = 0; v < 256; v++) begin
            n = 0; put(32'h80, 8); put(v, 8); send(v % 7 == 0);
            chk(o_pidv, "R2 pid_vld timing", o_pidv, 1);
            chk(o_raw == v[7:0], "R3 pid_raw", o_raw, v);
            chk(o_kind == exp_kind(v[7:0]), "R2 pid_kind", o_kind, exp_kind(v[7:0]));
            chk(!o_sync, "R1 good sync", o_sync, 0);
            chk(o_len == (exp_kind(v[7:0]) inside {4'd1, 4'd2, 4'd3, 4'd4}), "R6 short packet",
                o_len, exp_kind(v[7:0]) inside {4'd1, 4'd2, 4'd3, 4'd4});
            chk(!o_tok && !o_frm, "R6 no fields when short", {o_tok, o_frm}, 0);
        end

        // R1: each single-bit corruption of the sync byte, plus all zeros
        for (int b = 0; b < 9; b++) begin
            n = 0; put((b == 8) ? 32'h00 : (32'h80 ^ (32'h1 << b)), 8); put(32'hD2, 8); send(0);
            chk(o_sync, "R1 bad sync flagged", o_sync, 1);
        end

        // R4: all addresses across the three token kinds
        for (int a = 0; a < 128; a++) begin
            logic [7:0] p;
            p = (a % 3 == 0) ? 8'hE1 : (a % 3 == 1) ? 8'h69 : 8'h2D;
            n = 0; put(32'h80, 8); put(p, 8); put(a, 7); put((a * 5) & 15, 4); put(a & 31, 5);
            send(a % 16 == 3);
            chk(o_tok && !o_frm && !o_len, "R4 tok_vld", {o_tok, o_frm, o_len}, 3'b100);
            chk(o_addr == a[6:0], "R4 address", o_addr, a);
            chk(o_ep == 4'((a * 5) & 15), "R4 endpoint", o_ep, (a * 5) & 15);
        end

        // R5: frame numbers
        for (int f = 0; f < 2048; f += 97) begin
            for (int e = 0; e < 2; e++) begin
                int fv;
                fv = (e == 1) ? (2047 - f) : f;
                n = 0; put(32'h80, 8); put(32'hA5, 8); put(fv, 11); put(fv & 31, 5); send(e == 1);
                chk(o_frm && !o_tok && !o_len, "R5 frame_vld", {o_frm, o_tok, o_len}, 3'b100);
                chk(o_fnum == fv[10:0], "R5 frame number", o_fnum, fv);
            end
        end

        // R6: token and SOF lengths off by one
        for (int k = 0; k < 4; k++) begin
            n = 0; put(32'h80, 8); put((k < 2) ? 32'hE1 : 32'hA5, 8); put(32'h5A5A5, (k % 2 == 0) ? 15 : 17);
            send(0);
            chk(o_len && !o_tok && !o_frm, "R6 length error", {o_len, o_tok, o_frm}, 3'b100);
        end

        // R7 R8 R9: payload lengths 0..10 bytes, with and without gaps
        for (int L = 0; L <= 10; L++) begin
            for (int g = 0; g < 2; g++) begin
                n = 0; put(32'h80, 8); put((L % 2 == 0) ? 32'hC3 : 32'h4B, 8);
                for (int k = 0; k < L; k++) put((L * 37 + k * 11 + 5 + g * 90) & 255, 8);
                put(32'hFFFF ^ (L * 257), 16);
                send(g == 1);
                chk(nrx == L, "R7 byte count", nrx, L);
                for (int k = 0; k < L && k < nrx; k++) begin
                    chk(rx[k] == 8'((L * 37 + k * 11 + 5 + g * 90) & 255), "R7 byte value",
                        rx[k], (L * 37 + k * 11 + 5 + g * 90) & 255);
                    chk(rx_last[k] == (k == L - 1), "R8 last flag position", rx_last[k], k == L - 1);
                end
                chk(o_last == (L > 0), "R8 last one cycle after eop (R9 gaps)", o_last, L > 0);
                chk(!o_len && !o_tok, "R7 no token outputs", {o_len, o_tok}, 0);
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule